// File: doc/BRIEF.md
# Transition-Handshake Clock-Gating Wrapper

This block lets a locally clocked compute core sit on a network whose links are not timed to a shared clock. Each side of the wrapper is a data word with a request line and an acknowledge line. The lines signal by transition: any change of level, whether up or down, is one event, and no line ever returns to zero. When the input request differs from the acknowledge that the wrapper holds, a new word is waiting. The wrapper latches the word, hands it to the core and raises the core's enable, which stands in for a gated local clock.

The core reports completion with a done pulse. The wrapper then drops the enable, registers the result and toggles its output request once the data is settled. It waits until the far end toggles the output acknowledge to match. Only then does it toggle the input acknowledge. The wrapper is therefore a single-entry stage that passes back-pressure upstream. Both incoming control lines go through two-flop synchronisers before they are compared.

Four states sequence this work. IDLE waits for an input event and moves to RUN on `new_in`. RUN keeps the core enabled and moves to EMIT on `core_done`. EMIT toggles the output request and moves to DRAIN. DRAIN waits for the output acknowledge and, on `out_accepted`, toggles the input acknowledge and returns to IDLE.

Top module: `tgate_wrap`

## Requirements
- R1: While reset is held and right after it, `in_ack`, `out_req` and `core_en` are 0.
- R2: An input event is present when the synchronised `in_req` differs from `in_ack`; the transition may be in either direction. On an input event the wrapper latches `in_data` onto `core_arg` and raises `core_en`.
- R3: `core_en` stays high until `core_done` is seen and falls in the cycle after it. With a core that finishes after N enabled cycles, each transaction gives exactly N enabled cycles.
- R4: `out_data` carries the core result registered on `core_done`. It is already valid when `out_req` toggles and holds steady until `out_ack` matches `out_req`.
- R5: `out_req` toggles exactly once for each accepted input word, and the results come out in input order.
- R6: `in_ack` toggles, becoming equal to `in_req`, only after `out_ack` has matched `out_req` for the pending output. Before that the input stays unacknowledged.
- R7: Changes on `in_data` after the input event has been latched have no effect on the result.
- R8: `out_req` never toggles while an earlier output event is still unacknowledged.
- R9: With no pending input event, `core_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling / local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DW | Incoming data word |
| in_req | input | 1 | Incoming request, transition signalled |
| in_ack | output | 1 | Incoming acknowledge, transition signalled |
| out_data | output | DW | Outgoing data word |
| out_req | output | 1 | Outgoing request, transition signalled |
| out_ack | input | 1 | Outgoing acknowledge, transition signalled |
| core_en | output | 1 | Enable for the inner core (gated clock model) |
| core_arg | output | DW | Latched operand for the core |
| core_done | input | 1 | Core finished its computation |
| core_res | input | DW | Core result, valid with core_done |

## Verification
A wrong state in this block shows up at the ports within a few cycles. If the core stays enabled after done, or is enabled with no pending input, the per-transaction count of enabled cycles is wrong. If the output request toggles twice, or toggles before the data settles, the scoreboard sees an extra item or a mismatched word. If the input is acknowledged too early, `in_ack` equals `in_req` while the output is still unacknowledged. The bench holds the output acknowledge for different delays and corrupts `in_data` during a transaction, so the back-pressure path and the latched operand are both exercised.

// File: rtl/tgate_pkg.sv
`timescale 1ns/1ps
package tgate_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_EMIT  = 2'd2,
        ST_DRAIN = 2'd3
    } tgate_state_e;
endpackage

// File: rtl/tgate_sync.sv
`timescale 1ns/1ps
module tgate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tgate_fsm.sv
`timescale 1ns/1ps
module tgate_fsm
    import tgate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic oack_s,
    input  logic core_done,
    output logic ack_q,
    output logic oreq_q,
    output logic core_en,
    output logic cap_arg,
    output logic cap_res
);
    tgate_state_e state, state_nx;
    logic new_in, out_accepted, tog_oreq, tog_ack;

    assign new_in       = (req_s != ack_q);
    assign out_accepted = (oack_s == oreq_q);

    // state register and handshake line registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ack_q  <= 1'b0;
            oreq_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (tog_ack)  ack_q  <= ~ack_q;
            if (tog_oreq) oreq_q <= ~oreq_q;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        core_en  = 1'b0;
        cap_arg  = 1'b0;
        cap_res  = 1'b0;
        tog_oreq = 1'b0;
        tog_ack  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (new_in) begin
                    cap_arg  = 1'b1;
                    state_nx = ST_RUN;
                end
            end
            ST_RUN: begin
                core_en = 1'b1;
                if (core_done) begin
                    cap_res  = 1'b1;
                    state_nx = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (out_accepted) begin
                    tog_oreq = 1'b1;
                    state_nx = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (out_accepted) begin
                    tog_ack  = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    AST_EN_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_en) |-> $past(req_s != ack_q)); // R2
    AST_EN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en && core_done) |=> !core_en); // R3
    AST_ACK_AFTER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q != $past(ack_q)) |-> $past(oack_s == oreq_q)); // R6
    AST_ONE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (oreq_q != $past(oreq_q)) |-> $past(oack_s == oreq_q)); // R8
    AST_IDLE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !core_en); // R9
endmodule

// File: rtl/tgate_wrap.sv
`timescale 1ns/1ps
module tgate_wrap #(
    parameter int DW        = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] in_data,
    input  logic          in_req,
    output logic          in_ack,
    output logic [DW-1:0] out_data,
    output logic          out_req,
    input  logic          out_ack,
    output logic          core_en,
    output logic [DW-1:0] core_arg,
    input  logic          core_done,
    input  logic [DW-1:0] core_res
);
    logic req_s, oack_s, ack_q, oreq_q, cap_arg, cap_res;
    logic [DW-1:0] arg_q, res_q;

    tgate_sync #(.STAGES(SYNC_DEPTH)) u_sync_req (
        .clk(clk), .rst_n(rst_n), .d(in_req), .q(req_s));
    tgate_sync #(.STAGES(SYNC_DEPTH)) u_sync_oack (
        .clk(clk), .rst_n(rst_n), .d(out_ack), .q(oack_s));

    tgate_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_s(req_s), .oack_s(oack_s),
        .core_done(core_done), .ack_q(ack_q), .oreq_q(oreq_q),
        .core_en(core_en), .cap_arg(cap_arg), .cap_res(cap_res));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_q <= '0;
            res_q <= '0;
        end else begin
            if (cap_arg) arg_q <= in_data;
            if (cap_res) res_q <= core_res;
        end
    end

    assign in_ack   = ack_q;
    assign out_req  = oreq_q;
    assign out_data = res_q;
    assign core_arg = arg_q;

    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (oreq_q != oack_s) |=> $stable(res_q)); // R4
    AST_ARG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |=> $stable(arg_q)); // R7
endmodule

// File: tb/sim_tgate_wrap.sv
`timescale 1ns/1ps
module sim_tgate_wrap;
    localparam int DW  = 16;
    localparam int LAT = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [DW-1:0] in_data = '0, out_data, core_arg, core_res;
    logic in_req = 1'b0, in_ack, out_req, out_ack = 1'b0, core_en, core_done;
    int tests = 0, fails = 0, en_cnt = 0, outs = 0, sent = 0, ack_delay = 0;
    int cnt = 0;
    logic seen_req = 1'b0;
    logic [DW-1:0] exp_q[$];

    always #4 clk = ~clk;

    tgate_wrap #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_req(in_req), .in_ack(in_ack),
        .out_data(out_data), .out_req(out_req), .out_ack(out_ack), .core_en(core_en),
        .core_arg(core_arg), .core_done(core_done), .core_res(core_res));

    // bench-side core: finishes after LAT enabled cycles
    always @(posedge clk) begin
        if (!rst_n || !core_en) cnt <= 0;
        else                    cnt <= cnt + 1;
    end
    assign core_done = core_en && (cnt == LAT-1);
    assign core_res  = core_arg * 16'd5 + 16'd3;

    function automatic logic [DW-1:0] model(input logic [DW-1:0] x);
        return x * 16'd5 + 16'd3;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    always @(negedge clk) if (rst_n && core_en) en_cnt++;

    // monitor / scoreboard / output acknowledger
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_req != seen_req) begin
                logic [DW-1:0] e;
                seen_req = out_req;
                outs++;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : '1;
                check(out_data == e, "R4 out_data", out_data, e);
                check(en_cnt == LAT, "R3 enabled cycles", en_cnt, LAT);
                en_cnt = 0;
                check(in_ack != in_req, "R6 input unacked while output pending", in_ack, ~in_req);
                for (int i = 0; i < ack_delay; i++) begin
                    @(negedge clk);
                    check(out_data == e, "R4 out_data held", out_data, e);
                    check(out_req == seen_req, "R8 no second out_req", out_req, seen_req);
                end
                out_ack = out_req;
            end
        end
    end

    task automatic wait_ack();
        int guard = 0;
        while (in_ack != in_req && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic send(input logic [DW-1:0] d, input bit corrupt);
        wait_ack();
        @(negedge clk);
        in_data = d;
        in_req  = ~in_req;
        exp_q.push_back(model(d));
        sent++;
        if (corrupt) begin
            repeat (4) @(negedge clk);
            in_data = ~d;   // R7: must not affect the result
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(in_ack == 1'b0, "R1 in_ack", in_ack, 0);
        check(out_req == 1'b0, "R1 out_req", out_req, 0);
        check(core_en == 1'b0, "R1 core_en", core_en, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(core_en == 1'b0 && in_ack == 1'b0, "R1 after reset", core_en, 0);
        // R9: idle, no request
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(core_en == 1'b0, "R9 idle gated", core_en, 0);
        end
        // R2 R5 rising and falling transitions, varied acknowledge delays
        ack_delay = 0;  send(16'h0001, 0);
        ack_delay = 1;  send(16'h1234, 0);
        ack_delay = 5;  send(16'hFFFF, 0);
        ack_delay = 12; send(16'h00A5, 1);   // R7 corrupted after latch
        ack_delay = 2;  send(16'h7F00, 1);   // R7
        wait_ack();
        check(in_ack == in_req, "R6 input acked after output accepted", in_ack, in_req);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(core_en == 1'b0, "R9 gap gated", core_en, 0);
        end
        ack_delay = 3;  send(16'h4321, 0);
        ack_delay = 0;  send(16'h0000, 0);
        ack_delay = 7;  send(16'hBEEF, 0);
        wait_ack();
        repeat (10) @(negedge clk);
        check(outs == sent, "R5 one output per input", outs, sent);
        check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
        check(in_ack == in_req, "R2 final ack level", in_ack, in_req);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule